// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit

This block is the working register of a small processor datapath: a single accumulator that is combined, once per issued operation, with an operand taken from the data bus. The operand may be bit-complemented on its way in, and one of four functions is applied: addition with carry, exclusive-or, a bitwise AND/OR pair, or a plain load of the operand. Because the complementer sits in front of the adder, the same hardware negates, complements and subtracts with or without an incoming borrow.

Every issued operation produces four condition bits that microcode may branch on in the next cycle. These are carry (a borrow when subtracting), signed overflow, an all-zero result and a result with at least one zero lane. Writing the result back into the accumulator has its own enable. Clearing it turns any operation into a compare or a test that updates only the condition bits. The block has no increment or decrement of its own. A small constant must come in as the operand.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high `rst` sets the accumulator and all four condition bits to 0 by the next rising edge.
- R2: With `fn` = 2'b00 (ADD) the result is accumulator + operand + effective carry-in, taken modulo 2^DATA_W. The effective carry-in is `cin_sel` XOR `inv_en`.
- R3: With `fn` = 2'b01 (XOR) the result is the accumulator XOR the operand.
- R4: With `fn` = 2'b10 the result is accumulator AND operand when `cin_sel` = 0, and accumulator OR operand when `cin_sel` = 1.
- R5: With `fn` = 2'b11 (LOAD) the result is the operand itself.
- R6: When `inv_en` = 1 the operand is the bitwise complement of `data_in`, and carry is taken in inverted sense on input and output. So `fn`=00, `inv_en`=1, `cin_sel`=b gives accumulator − data − b, and `flag_cy` = 1 marks a borrow.
- R7: For every function, `flag_cy` is the carry out of the adder XOR `inv_en`. `flag_ov` is set exactly when both adder inputs have the same sign bit and the adder sum has the other sign.
- R8: `flag_zero` is 1 exactly when the selected function's result is zero.
- R9: `flag_lane_zero` is 1 when at least one LANE_W-bit lane of the selected function's result is zero.
- R10: The accumulator takes the result only on an edge where `op_valid` and `load_en` are both 1. Otherwise it holds its value.
- R11: The condition bits update on every edge with `op_valid` = 1, including when `load_en` = 0. They hold their values when `op_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is issued this cycle |
| load_en | input | 1 | Write the result into the accumulator |
| fn | input | 2 | Function: 00 ADD, 01 XOR, 10 AND/OR, 11 LOAD |
| cin_sel | input | 1 | Carry-in for ADD; AND(0)/OR(1) choice for fn 10 |
| inv_en | input | 1 | Complement the operand, invert the carry sense |
| data_in | input | DATA_W | Data-bus operand |
| acc | output | DATA_W | Accumulator contents |
| flag_cy | output | 1 | Registered carry / borrow |
| flag_ov | output | 1 | Registered signed overflow |
| flag_zero | output | 1 | Registered all-zero result |
| flag_lane_zero | output | 1 | Registered some-lane-zero result |

## Verification
The bench builds one copy with DATA_W = 4 and LANE_W = 2. At that size every accumulator value, every operand, both carry-in values, both inverter settings and all four functions can be swept, each with the write-back on or off. This reaches every carry, overflow and lane-zero combination. A second copy at the default 16-bit width with 8-bit lanes gets directed cases: the signed boundary at 0x7FFF/0x8000, subtraction with borrow, and a zero high or low byte.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [1:0] {
        FN_ADD   = 2'b00,
        FN_XOR   = 2'b01,
        FN_ANDOR = 2'b10,
        FN_LOAD  = 2'b11
    } alu_fn_e;

endpackage

// File: rtl/alu_operand.sv
// Operand conditioning: optional complement of the bus word and the
// matching inversion of the carry sense.
module alu_operand #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic              inv_en,
    input  logic              cin_sel,
    output logic [DATA_W-1:0] opnd,
    output logic              cin_eff
);
    always_comb begin
        opnd    = inv_en ? ~data_in : data_in;
        cin_eff = cin_sel ^ inv_en;
    end
endmodule

// File: rtl/alu_adder.sv
// Adder with carry out of the top bit and carry into the top bit.
module alu_adder #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              ci,
    output logic [DATA_W-1:0] sum,
    output logic              co,
    output logic              c_msb
);
    localparam int LOW_W = DATA_W - 1;

    logic [DATA_W:0] full;
    logic [LOW_W:0]  low;

    always_comb begin
        full  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
        low   = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]} + {{LOW_W{1'b0}}, ci};
        sum   = full[DATA_W-1:0];
        co    = full[DATA_W];
        c_msb = low[LOW_W];
    end
endmodule

// File: rtl/alu_logic.sv
// Function selection: picks the adder sum, a bitwise result or the operand.
module alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] sum,
    input  logic              or_sel,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        unique case (fn)
            FN_ADD:   result = sum;
            FN_XOR:   result = a ^ b;
            FN_ANDOR: result = or_sel ? (a | b) : (a & b);
            default:  result = b;
        endcase
    end
endmodule

// File: rtl/alu_zero_detect.sv
// Whole-word and per-lane zero detection.
module alu_zero_detect #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] value,
    output logic              all_zero,
    output logic              any_lane_zero
);
    localparam int N_LANES = DATA_W / LANE_W;

    logic [N_LANES-1:0] lane_z;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lane_z[g] = (value[g*LANE_W +: LANE_W] == '0);
    end

    always_comb begin
        all_zero      = (value == '0);
        any_lane_zero = |lane_z;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              load_en,
    input  logic [1:0]        fn,
    input  logic              cin_sel,
    input  logic              inv_en,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] acc,
    output logic              flag_cy,
    output logic              flag_ov,
    output logic              flag_zero,
    output logic              flag_lane_zero
);
    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              cy;
        logic              ov;
        logic              zero;
        logic              lane_zero;
    } alu_state_t;

    alu_state_t st_d, st_q;

    logic [DATA_W-1:0] opnd;
    logic              cin_eff;
    logic [DATA_W-1:0] sum;
    logic              co;
    logic              c_msb;
    logic [DATA_W-1:0] result;
    logic              res_zero;
    logic              res_lane_zero;
    alu_fn_e           fn_e;

    assign fn_e = alu_fn_e'(fn);

    alu_operand #(.DATA_W(DATA_W)) u_opnd (
        .data_in (data_in),
        .inv_en  (inv_en),
        .cin_sel (cin_sel),
        .opnd    (opnd),
        .cin_eff (cin_eff)
    );

    alu_adder #(.DATA_W(DATA_W)) u_add (
        .a     (st_q.acc),
        .b     (opnd),
        .ci    (cin_eff),
        .sum   (sum),
        .co    (co),
        .c_msb (c_msb)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .fn     (fn_e),
        .a      (st_q.acc),
        .b      (opnd),
        .sum    (sum),
        .or_sel (cin_sel),
        .result (result)
    );

    alu_zero_detect #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_zero (
        .value         (result),
        .all_zero      (res_zero),
        .any_lane_zero (res_lane_zero)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            if (load_en) begin
                st_d.acc = result;
            end
            st_d.cy        = co ^ inv_en;
            st_d.ov        = c_msb ^ co;
            st_d.zero      = res_zero;
            st_d.lane_zero = res_lane_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc            = st_q.acc;
    assign flag_cy        = st_q.cy;
    assign flag_ov        = st_q.ov;
    assign flag_zero      = st_q.zero;
    assign flag_lane_zero = st_q.lane_zero;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic              load_en,
    input logic [1:0]        fn,
    input logic              inv_en,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] acc,
    input logic              flag_cy,
    input logic              flag_ov,
    input logic              flag_zero,
    input logic              flag_lane_zero
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc == '0 && !flag_cy && !flag_ov && !flag_zero && !flag_lane_zero));

    assert_load_copies_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && load_en && fn == 2'b11 && !inv_en) |=> acc == $past(data_in));

    assert_zero_matches_acc_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && load_en) |=> (flag_zero == (acc == '0)));

    assert_zero_implies_lane_R9: assert property (@(posedge clk) disable iff (rst)
        flag_zero |-> flag_lane_zero);

    assert_acc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && load_en) |=> $stable(acc));

    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(flag_cy) && $stable(flag_ov) && $stable(flag_zero)
                       && $stable(flag_lane_zero)));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .op_valid       (op_valid),
    .load_en        (load_en),
    .fn             (fn),
    .inv_en         (inv_en),
    .data_in        (data_in),
    .acc            (acc),
    .flag_cy        (flag_cy),
    .flag_ov        (flag_ov),
    .flag_zero      (flag_zero),
    .flag_lane_zero (flag_lane_zero)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // small instance: 4-bit word, 2-bit lanes
    logic       s_valid = 0, s_load = 0, s_cin = 0, s_inv = 0;
    logic [1:0] s_fn = 0;
    logic [3:0] s_data = 0;
    logic [3:0] s_acc;
    logic       s_cy, s_ov, s_z, s_lz;

    // wide instance: default 16-bit word, 8-bit lanes
    logic        w_valid = 0, w_load = 0, w_cin = 0, w_inv = 0;
    logic [1:0]  w_fn = 0;
    logic [15:0] w_data = 0;
    logic [15:0] w_acc;
    logic        w_cy, w_ov, w_z, w_lz;

    acc_alu #(.DATA_W(4), .LANE_W(2)) dut_i (
        .clk(clk), .rst(rst), .op_valid(s_valid), .load_en(s_load), .fn(s_fn),
        .cin_sel(s_cin), .inv_en(s_inv), .data_in(s_data), .acc(s_acc),
        .flag_cy(s_cy), .flag_ov(s_ov), .flag_zero(s_z), .flag_lane_zero(s_lz)
    );

    acc_alu dut_wide_i (
        .clk(clk), .rst(rst), .op_valid(w_valid), .load_en(w_load), .fn(w_fn),
        .cin_sel(w_cin), .inv_en(w_inv), .data_in(w_data), .acc(w_acc),
        .flag_cy(w_cy), .flag_ov(w_ov), .flag_zero(w_z), .flag_lane_zero(w_lz)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference computed from the requirements.
    task automatic model(input int w, input int lw, input int f, input bit inv,
                         input bit cin, input longint a, input longint d,
                         output longint res, output bit cy, output bit ov,
                         output bit z, output bit lz);
        longint mask, opnd, full, sm, lmask;
        bit     sa, sb, ss, ci;
        mask  = (longint'(1) << w) - 1;
        opnd  = inv ? (mask - d) : d;
        ci    = cin ^ inv;
        full  = a + opnd + longint'(ci);
        sm    = full & mask;
        cy    = bit'((full >> w) & 1) ^ inv;
        sa    = bit'((a >> (w - 1)) & 1);
        sb    = bit'((opnd >> (w - 1)) & 1);
        ss    = bit'((sm >> (w - 1)) & 1);
        ov    = (sa == sb) && (ss != sa);
        case (f)
            0:       res = sm;
            1:       res = a ^ opnd;
            2:       res = cin ? (a | opnd) : (a & opnd);
            default: res = opnd;
        endcase
        z     = (res == 0);
        lz    = 1'b0;
        lmask = (longint'(1) << lw) - 1;
        for (int k = 0; k < w / lw; k++) begin
            if (((res >> (k * lw)) & lmask) == 0) lz = 1'b1;
        end
    endtask

    function automatic string tag(input int f, input bit inv);
        if (inv && f == 0) return "R6";
        case (f)
            0:       return "R2";
            1:       return "R3";
            2:       return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic run_small(input int f, input bit inv, input bit cin,
                             input int a, input int d, input bit ld, input bit hold);
        longint res;
        bit cy, ov, z, lz;
        model(4, 2, f, inv, cin, a, d, res, cy, ov, z, lz);
        @(negedge clk);
        s_valid = 1; s_load = 1; s_fn = 2'b11; s_inv = 0; s_cin = 0; s_data = 4'(a);
        @(negedge clk);
        s_valid = 1; s_load = ld; s_fn = 2'(f); s_inv = inv; s_cin = cin; s_data = 4'(d);
        @(negedge clk);
        s_valid = 0;
        chk(ld ? tag(f, inv) : "R10", s_acc, ld ? res : a);
        chk("R7 cy", s_cy, cy);
        chk("R7 ov", s_ov, ov);
        chk(ld ? "R8" : "R11 flags with no load", s_z, z);
        chk("R9", s_lz, lz);
        if (hold) begin
            s_fn = 2'(~f); s_inv = ~inv; s_cin = ~cin; s_data = 4'(~d); s_load = 1;
            @(negedge clk);
            chk("R11 hold z", s_z, z);
            chk("R11 hold cy", s_cy, cy);
            chk("R10 hold acc", s_acc, ld ? res : a);
        end
    endtask

    task automatic run_wide(input int f, input bit inv, input bit cin,
                            input int a, input int d);
        longint res;
        bit cy, ov, z, lz;
        model(16, 8, f, inv, cin, a, d, res, cy, ov, z, lz);
        @(negedge clk);
        w_valid = 1; w_load = 1; w_fn = 2'b11; w_inv = 0; w_cin = 0; w_data = 16'(a);
        @(negedge clk);
        w_valid = 1; w_load = 1; w_fn = 2'(f); w_inv = inv; w_cin = cin; w_data = 16'(d);
        @(negedge clk);
        w_valid = 0;
        chk(tag(f, inv), w_acc, res);
        chk("R7 wide cy", w_cy, cy);
        chk("R7 wide ov", w_ov, ov);
        chk("R8 wide", w_z, z);
        chk("R9 wide", w_lz, lz);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: drive a load during reset; it must be ignored
        s_valid = 1; s_load = 1; s_fn = 2'b11; s_data = 4'hF;
        w_valid = 1; w_load = 1; w_fn = 2'b11; w_data = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 0;
        s_valid = 0; w_valid = 0;
        chk("R1 acc", s_acc, 0);
        chk("R1 cy", s_cy, 0);
        chk("R1 zero", s_z, 0);
        chk("R1 wide acc", w_acc, 0);
        chk("R1 wide lane", w_lz, 0);

        for (int f = 0; f < 4; f++)
            for (int iv = 0; iv < 2; iv++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < 16; a++)
                        for (int d = 0; d < 16; d++)
                            run_small(f, bit'(iv), bit'(c), a, d,
                                      bit'((a ^ d ^ c) & 1), (a == d));

        run_wide(0, 0, 0, 16'h7FFF, 16'h0001);   // signed overflow, low byte zero
        run_wide(0, 0, 1, 16'hFFFF, 16'h0000);   // carry out, all zero
        run_wide(0, 1, 0, 16'h0005, 16'h0007);   // subtract with borrow out
        run_wide(0, 1, 1, 16'h1000, 16'h0FFF);   // subtract with borrow in
        run_wide(0, 1, 0, 16'h8000, 16'h0001);   // signed overflow on subtract
        run_wide(0, 1, 0, 16'h0000, 16'h0001 - 16'h0001); // zero minus zero
        run_wide(1, 0, 0, 16'h12AB, 16'h12CD);   // high byte zero
        run_wide(2, 0, 0, 16'hF0F0, 16'h0FF0);
        run_wide(2, 0, 1, 16'hF000, 16'h000F);
        run_wide(3, 1, 0, 16'h1234, 16'h0000);   // load complement
        run_wide(3, 0, 0, 16'hABCD, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule